// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block watches a set of external interrupt pins (four by default) and turns their activity into one request line per pin. Each pin has a two-bit sense field that picks what counts as an event on that pin: a held low level, any transition, a high-to-low transition or a low-to-high transition. Every pin goes through a two-flop synchroniser on the system clock. Transitions are found by comparing the synchronised sample with the one from the cycle before.

In the three transition modes a detected event sets a sticky per-pin flag. The flag is set even while the pin is masked. The pin's request is that flag gated by the pin's mask bit and by a global enable. Software clears a flag by writing a one to it. An acknowledge pulse from the interrupt logic also clears it. In low-level mode the flag is not used: the request follows the synchronised low level directly, gated the same way.

Software reaches three registers through a simple write port and a combinational read port: sense control, mask and flags. The block does no vectoring and no priority arbitration between pins.

Top module: `ext_irq_ctrl`

## Requirements
- R1: Sense control sits at address 0. Pin n's field is bits [2n+1:2n], so pin 3 uses bits 7:6 and pin 0 uses bits 1:0. The field values are: 00 low level, 01 any edge, 10 falling edge, 11 rising edge.
- R2: After reset, sense control, mask and flags all read zero and every request output is low.
- R3: A request for pin n is high only while both `glb_en` and mask bit n are set.
- R4: In low-level mode the request for pin n rises two clock edges after the pin goes low. It stays high as long as the pin is held low and falls two edges after the pin returns high. This mode never sets the pin's flag.
- R5: In an edge mode, a matching transition sets flag n three clock edges after the pin changes, whatever the mask and global enable are. A non-matching transition leaves the flag clear. The request equals the flag gated by mask bit n and `glb_en`.
- R6: A write to address 2 clears every flag whose data bit is one. Flags whose data bit is zero keep their value.
- R7: A one-cycle pulse on `irq_ack[n]` clears flag n.
- R8: If a matching transition is detected in the same cycle as a clear of that flag (by acknowledge or by write), the flag ends up set.
- R9: The synchroniser starts at logic high. Pins that are high through reset therefore create no flag, even after rising-edge or any-edge modes are selected.
- R10: Address 1 reads the mask in bits [NUM_PINS-1:0] and zeros above them. Address 2 reads the flags in the same way. Address 3 reads all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NUM_PINS | External interrupt pins, asynchronous |
| glb_en | input | 1 | Global interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 sense, 1 mask, 2 flags (write one to clear) |
| wr_data | input | 2*NUM_PINS | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 2*NUM_PINS | Read data, combinational from rd_addr |
| irq_ack | input | NUM_PINS | Per-pin acknowledge pulse that clears the flag |
| irq_req | output | NUM_PINS | Per-pin interrupt request |

## Verification
A detected transition that sets a flag can land in the same cycle as a clear of that flag. The clear can come from the acknowledge input or from a write-one to the flag register. The bench first sets the flag with one any-edge transition. It then makes a second transition and counts register stages so that the detection cycle matches the cycle in which the acknowledge or the write is sampled. It reads the flag back afterwards and expects it set. If the clear won, the flag would read zero.

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int NUM_PINS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pin_in,
  input  logic                  glb_en,
  input  logic                  wr_en,
  input  logic [1:0]            wr_addr,
  input  logic [2*NUM_PINS-1:0] wr_data,
  input  logic [1:0]            rd_addr,
  output logic [2*NUM_PINS-1:0] rd_data,
  input  logic [NUM_PINS-1:0]   irq_ack,
  output logic [NUM_PINS-1:0]   irq_req
);
  localparam int RW = 2 * NUM_PINS;
  localparam logic [1:0] A_SENSE = 2'd0, A_MASK = 2'd1, A_FLAG = 2'd2;

  logic [RW-1:0]       sense_q;
  logic [NUM_PINS-1:0] mask_q, flag_q;
  logic [NUM_PINS-1:0] sync1_q, sync2_q, prev_q;
  logic [NUM_PINS-1:0] hit, clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '1;
      sync2_q <= '1;
      prev_q  <= '1;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sense_q <= '0;
      mask_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_SENSE) sense_q <= wr_data;
      if (wr_addr == A_MASK)  mask_q  <= wr_data[NUM_PINS-1:0];
    end
  end

  assign clr = irq_ack | ((wr_en && wr_addr == A_FLAG) ? wr_data[NUM_PINS-1:0] : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr) | hit;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [1:0] mode;
    logic       rise, fall;
    assign mode = sense_q[2*i +: 2];
    assign rise = sync2_q[i] & ~prev_q[i];
    assign fall = ~sync2_q[i] & prev_q[i];

    always_comb begin
      case (mode)
        2'b01:   hit[i] = rise | fall;
        2'b10:   hit[i] = fall;
        2'b11:   hit[i] = rise;
        default: hit[i] = 1'b0;
      endcase
    end

    assign irq_req[i] = glb_en & mask_q[i] & ((mode == 2'b00) ? ~sync2_q[i] : flag_q[i]);

    AST_RISE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11 && sync2_q[i] && !prev_q[i]) |=> flag_q[i]); // R5
    AST_LEVEL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00 && !flag_q[i]) |=> !flag_q[i]); // R4
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_FLAG && wr_data[i] && !hit[i]) |=> !flag_q[i]); // R6
    AST_W0_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_FLAG && !wr_data[i] && !irq_ack[i] && flag_q[i]) |=> flag_q[i]); // R6
    AST_ACK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack[i] && !hit[i]) |=> !flag_q[i]); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && clr[i]) |=> flag_q[i]); // R8
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_SENSE: rd_data = sense_q;
      A_MASK:  rd_data[NUM_PINS-1:0] = mask_q;
      A_FLAG:  rd_data[NUM_PINS-1:0] = flag_q;
      default: rd_data = '0;
    endcase
  end

  AST_GATED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_req & ~(mask_q & {NUM_PINS{glb_en}})) == '0)); // R3
endmodule

// File: tb/ext_irq_ctrl_tb.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pin_in = 4'hF;
  logic       glb_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [3:0] irq_ack = '0;
  logic [3:0] irq_req;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  ext_irq_ctrl #(.NUM_PINS(4)) u_dut (.*);

  // {mode, from_level, to_level, expected flag}
  localparam logic [4:0] VEC [8] = '{
    {2'b01, 1'b1, 1'b0, 1'b1}, {2'b01, 1'b0, 1'b1, 1'b1},
    {2'b10, 1'b1, 1'b0, 1'b1}, {2'b10, 1'b0, 1'b1, 1'b0},
    {2'b11, 1'b0, 1'b1, 1'b1}, {2'b11, 1'b1, 1'b0, 1'b0},
    {2'b00, 1'b1, 1'b0, 1'b0}, {2'b00, 1'b0, 1'b1, 1'b0}};

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    rd_addr = a; #0.1;
    chk(req, rd_data, exp);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(4);
    rst_n = 1'b1;
    step(1);
    // R2 reset state
    rd_chk("R2", 2'd0, 8'h00);
    rd_chk("R2", 2'd1, 8'h00);
    rd_chk("R2", 2'd2, 8'h00);
    chk("R2", {4'h0, irq_req}, 8'h00);
    // R9 pins high at reset: no flags even in edge modes
    wr(2'd0, 8'hFF);
    step(5);
    rd_chk("R9", 2'd2, 8'h00);
    wr(2'd0, 8'h55);
    step(5);
    rd_chk("R9", 2'd2, 8'h00);

    // vector table on pin 0 (R1, R4, R5)
    for (int v = 0; v < 8; v++) begin
      wr(2'd0, {6'b0, VEC[v][4:3]});
      pin_in[0] = VEC[v][2];
      step(5);
      wr(2'd2, 8'hFF);
      pin_in[0] = VEC[v][1];
      step(5);
      rd_chk(VEC[v][4:3] == 2'b00 ? "R4" : "R5", 2'd2, {7'b0, VEC[v][0]});
    end
    pin_in = 4'hF;
    step(5);
    wr(2'd2, 8'hFF);

    // R1 field packing: pin 3 rising, pin 0 low-level
    wr(2'd0, 8'hC0);
    rd_chk("R1", 2'd0, 8'hC0);
    pin_in[3] = 1'b0; pin_in[0] = 1'b0;
    step(5);
    pin_in[3] = 1'b1; pin_in[0] = 1'b1;
    step(5);
    rd_chk("R1", 2'd2, 8'h08);
    wr(2'd2, 8'hFF);

    // R5 / R3: flag set while masked, gating
    wr(2'd0, 8'h03);
    pin_in[0] = 1'b0; step(3);
    pin_in[0] = 1'b1; step(3);
    rd_chk("R5", 2'd2, 8'h01);
    chk("R3", {4'h0, irq_req}, 8'h00);
    wr(2'd1, 8'hFF);
    rd_chk("R10", 2'd1, 8'h0F);
    rd_chk("R10", 2'd3, 8'h00);
    chk("R3", {4'h0, irq_req}, 8'h00);
    glb_en = 1'b1; #0.1;
    chk("R5", {4'h0, irq_req}, 8'h01);
    // R6 write zero keeps, write one clears
    wr(2'd2, 8'h00);
    rd_chk("R6", 2'd2, 8'h01);
    wr(2'd2, 8'h01);
    rd_chk("R6", 2'd2, 8'h00);
    chk("R6", {4'h0, irq_req}, 8'h00);
    // R7 acknowledge clears
    pin_in[0] = 1'b0; step(3);
    pin_in[0] = 1'b1; step(3);
    rd_chk("R7", 2'd2, 8'h01);
    irq_ack[0] = 1'b1; step(1); irq_ack[0] = 1'b0;
    rd_chk("R7", 2'd2, 8'h00);
    chk("R7", {4'h0, irq_req}, 8'h00);

    // R4 low level on pin 1, exact latency
    wr(2'd0, 8'h00);
    pin_in[1] = 1'b0;
    step(1);
    chk("R4", {4'h0, irq_req}, 8'h00);
    step(1);
    chk("R4", {4'h0, irq_req}, 8'h02);
    step(6);
    chk("R4", {4'h0, irq_req}, 8'h02);
    glb_en = 1'b0; #0.1;
    chk("R3", {4'h0, irq_req}, 8'h00);
    glb_en = 1'b1;
    pin_in[1] = 1'b1;
    step(1);
    chk("R4", {4'h0, irq_req}, 8'h02);
    step(1);
    chk("R4", {4'h0, irq_req}, 8'h00);
    rd_chk("R4", 2'd2, 8'h00);

    // R8 set wins over acknowledge
    wr(2'd0, 8'h01);
    pin_in[0] = 1'b0; step(4);
    rd_chk("R8", 2'd2, 8'h01);
    pin_in[0] = 1'b1;
    step(2);
    irq_ack[0] = 1'b1; step(1); irq_ack[0] = 1'b0;
    rd_chk("R8", 2'd2, 8'h01);
    // R8 set wins over write-one clear
    pin_in[0] = 1'b0;
    step(2);
    wr(2'd2, 8'h01);
    rd_chk("R8", 2'd2, 8'h01);
    step(2);
    wr(2'd2, 8'h01);
    rd_chk("R6", 2'd2, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule